// File: doc/BRIEF.md
# Shared Result Bus Arbiter

Several functional units finish work independently, but only one result bus is available to carry completions to the waiting consumers. This block takes a result request from each unit, where each result is a producer tag and its data value. In every cycle it picks one requesting unit and places that unit's tag and value on the bus with a valid strobe. Consumers capture the bus in the same cycle it is driven. All other requesting units get a hold signal. They must keep their tag and value unchanged and try again in a later cycle.

Selection rotates among the units. Each time a unit is granted, the unit after it gets top priority. This means no unit can be locked out by busier neighbours. The grant, the hold flags and the bus outputs are all combinational from the requests and a single priority pointer register. A result is therefore accepted in the same cycle its request is seen, and a unit with a stream of results can present a new one every cycle.

Top module: `result_bus_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle, and a grant bit is only ever high for a unit whose `req_i` bit is high.
- R2: When any `req_i` bit is high, exactly one grant is given and `bus_valid_o` is high. When no request is present, `bus_valid_o` is low and both `bus_tag_o` and `bus_value_o` read 0.
- R3: In a cycle where unit k is granted, `bus_tag_o` equals unit k's tag field, `tag_i[k*TAG_W +: TAG_W]`, and `bus_value_o` equals `value_i[k*DATA_W +: DATA_W]`, in that same cycle.
- R4: `hold_o[k]` is high exactly when `req_i[k]` is high and `grant_o[k]` is low.
- R5: The pointer marks the unit with top priority. After reset, unit 0 has top priority. After a grant to unit k, the search for the next grant starts at unit (k+1) mod NUM_UNITS and moves upward with wrap-around. With all units requesting, the grants therefore run 0, 1, 2, ... in order.
- R6: In a cycle with no grant, the priority pointer keeps its value.
- R7: A unit that keeps its request asserted is granted within NUM_UNITS cycles, so it is held for at most NUM_UNITS-1 consecutive cycles.
- R8: An active-low reset `rst_n` returns the priority pointer to unit 0, even in the middle of traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_UNITS | Per-unit result-ready request |
| tag_i | input | NUM_UNITS*TAG_W | Per-unit producer tags, unit k in bits k*TAG_W upward |
| value_i | input | NUM_UNITS*DATA_W | Per-unit result values, unit k in bits k*DATA_W upward |
| grant_o | output | NUM_UNITS | One-hot acceptance of a unit's result this cycle |
| hold_o | output | NUM_UNITS | Per-unit back-pressure: keep the result and retry |
| bus_valid_o | output | 1 | Broadcast strobe |
| bus_tag_o | output | TAG_W | Tag on the broadcast bus |
| bus_value_o | output | DATA_W | Value on the broadcast bus |

## Verification
The hardest cases to reach are the starvation bound and the pointer wrap while most units are waiting. Both need several units to hold their results across many cycles while the grants pass over them in rotation. The stimulus reaches these states in three ways. First, it makes every unit keep a held result exactly as a real producer would. Second, it runs long stretches at high request density so that nearly all units wait at once. Third, it drains the queue and then idles, so that a later burst shows whether the pointer stayed where the last grant left it. A reset is also applied while results are pending, to confirm that priority returns to unit 0.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
   typedef enum logic {
      MUX_ANDOR = 1'b0,
      MUX_INDEX = 1'b1
   } mux_style_e;
endpackage

// File: rtl/rbus_rr_ptr.sv
module rbus_rr_ptr #(
   parameter int NUM_UNITS = 4,
   parameter int PW        = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_UNITS-1:0] grant_i,
   output logic [PW-1:0]        ptr_o
);
   logic [PW-1:0] ptr_nxt;

   always_comb begin
      ptr_nxt = ptr_o;
      for (int i = 0; i < NUM_UNITS; i++) begin
         if (grant_i[i]) begin
            ptr_nxt = (i == NUM_UNITS - 1) ? '0 : PW'(i + 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_o <= '0;
      else        ptr_o <= ptr_nxt;
   end

   AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_i == '0) |=> $stable(ptr_o)); // R6
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i[NUM_UNITS-1] |=> (ptr_o == '0)); // R5
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_o) < NUM_UNITS); // R5
endmodule

// File: rtl/rbus_rr_pick.sv
module rbus_rr_pick #(
   parameter int NUM_UNITS = 4,
   parameter int PW        = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic [NUM_UNITS-1:0] req_i,
   input  logic [PW-1:0]        ptr_i,
   output logic [NUM_UNITS-1:0] grant_o
);
   always_comb begin
      logic found;
      grant_o = '0;
      found   = 1'b0;
      for (int off = 0; off < NUM_UNITS; off++) begin
         int idx;
         idx = (int'(ptr_i) + off) % NUM_UNITS;
         if (!found && req_i[idx]) begin
            grant_o[idx] = 1'b1;
            found        = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rbus_mux.sv
module rbus_mux
   import rbus_pkg::*;
#(
   parameter int         NUM_UNITS = 4,
   parameter int         WIDTH     = 8,
   parameter mux_style_e STYLE     = MUX_ANDOR
) (
   input  logic [NUM_UNITS-1:0]       sel_i,
   input  logic [NUM_UNITS*WIDTH-1:0] data_i,
   output logic [WIDTH-1:0]           data_o
);
   generate
      if (STYLE == MUX_ANDOR) begin : g_andor
         always_comb begin
            data_o = '0;
            for (int i = 0; i < NUM_UNITS; i++) begin
               data_o = data_o | ({WIDTH{sel_i[i]}} & data_i[i*WIDTH +: WIDTH]);
            end
         end
      end else begin : g_index
         always_comb begin
            int idx;
            idx = 0;
            for (int i = 0; i < NUM_UNITS; i++) begin
               if (sel_i[i]) idx = i;
            end
            data_o = (|sel_i) ? data_i[idx*WIDTH +: WIDTH] : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/result_bus_arbiter.sv
module result_bus_arbiter
   import rbus_pkg::*;
#(
   parameter int         NUM_UNITS = 4,
   parameter int         TAG_W     = 5,
   parameter int         DATA_W    = 16,
   parameter mux_style_e MUX_STYLE = MUX_ANDOR
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_UNITS-1:0]        req_i,
   input  logic [NUM_UNITS*TAG_W-1:0]  tag_i,
   input  logic [NUM_UNITS*DATA_W-1:0] value_i,
   output logic [NUM_UNITS-1:0]        grant_o,
   output logic [NUM_UNITS-1:0]        hold_o,
   output logic                        bus_valid_o,
   output logic [TAG_W-1:0]            bus_tag_o,
   output logic [DATA_W-1:0]           bus_value_o
);
   localparam int PW   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
   localparam int EW   = TAG_W + DATA_W;

   generate
      if (NUM_UNITS < 2) begin : g_bad_units
         $error("result_bus_arbiter: NUM_UNITS must be at least 2");
      end
      if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("result_bus_arbiter: TAG_W and DATA_W must be positive");
      end
   endgenerate

   logic [PW-1:0]             ptr;
   logic [NUM_UNITS*EW-1:0]   entries;
   logic [EW-1:0]             bus_entry;

   genvar g;
   generate
      for (g = 0; g < NUM_UNITS; g++) begin : g_pack
         assign entries[g*EW +: EW] = {tag_i[g*TAG_W +: TAG_W], value_i[g*DATA_W +: DATA_W]};
      end
   endgenerate

   rbus_rr_pick #(.NUM_UNITS(NUM_UNITS), .PW(PW)) u_pick (
      .req_i   (req_i),
      .ptr_i   (ptr),
      .grant_o (grant_o)
   );

   rbus_rr_ptr #(.NUM_UNITS(NUM_UNITS), .PW(PW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant_i (grant_o),
      .ptr_o   (ptr)
   );

   rbus_mux #(.NUM_UNITS(NUM_UNITS), .WIDTH(EW), .STYLE(MUX_STYLE)) u_mux (
      .sel_i  (grant_o),
      .data_i (entries),
      .data_o (bus_entry)
   );

   assign bus_valid_o = |grant_o;
   assign bus_tag_o   = bus_entry[EW-1 -: TAG_W];
   assign bus_value_o = bus_entry[DATA_W-1:0];
   assign hold_o      = req_i & ~grant_o;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R1
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0); // R1
   AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o == (|req_i)); // R2
   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid_o |-> (bus_tag_o == '0 && bus_value_o == '0)); // R2
   AST_HOLD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((hold_o & grant_o) == '0) && ((hold_o | grant_o) == req_i)); // R4

   generate
      for (g = 0; g < NUM_UNITS; g++) begin : g_chk
         AST_BUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[g] |-> (bus_tag_o == tag_i[g*TAG_W +: TAG_W] &&
                            bus_value_o == value_i[g*DATA_W +: DATA_W])); // R3
      end
   endgenerate
endmodule

// File: tb/sim_result_bus_arbiter.sv
module sim_result_bus_arbiter;
   localparam int N  = 4;
   localparam int TW = 5;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [N-1:0]    req = '0;
   logic [N*TW-1:0] tag = '0;
   logic [N*DW-1:0] val = '0;
   logic [N-1:0]    grant, hold;
   logic            bv;
   logic [TW-1:0]   bt;
   logic [DW-1:0]   bval;

   result_bus_arbiter #(.NUM_UNITS(N), .TAG_W(TW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .tag_i(tag), .value_i(val),
      .grant_o(grant), .hold_o(hold), .bus_valid_o(bv),
      .bus_tag_o(bt), .bus_value_o(bval)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int ptr_m = 0;
   int waitc [N];
   logic [N-1:0] egr = '0;

   function automatic logic [N-1:0] rr_pick(input logic [N-1:0] r, input int p);
      logic [N-1:0] g = '0;
      for (int off = 0; off < N; off++) begin
         if (r[(p + off) % N]) begin
            g[(p + off) % N] = 1'b1;
            return g;
         end
      end
      return g;
   endfunction

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Sampled mid-cycle; model state then advances as the next edge will.
   task automatic eval_cycle();
      logic [TW-1:0] et;
      logic [DW-1:0] ev;
      et = '0;
      ev = '0;
      egr = rr_pick(req, ptr_m);
      for (int i = 0; i < N; i++) begin
         if (egr[i]) begin
            et = tag[i*TW +: TW];
            ev = val[i*DW +: DW];
         end
      end
      chk("R1 grant", grant, egr);
      chk("R2 valid", bv, |req);
      chk("R3 tag", bt, et);
      chk("R3 value", bval, ev);
      chk("R4 hold", hold, req & ~egr);
      for (int i = 0; i < N; i++) begin
         if (!rst_n || !req[i] || egr[i]) waitc[i] = 0;
         else begin
            waitc[i]++;
            if (waitc[i] > N - 1) chk("R7 wait bound", waitc[i], N - 1);
         end
      end
      if (rst_n) begin
         for (int i = 0; i < N; i++) if (egr[i]) ptr_m = (i + 1) % N;
      end
   endtask

   task automatic drive_next(input int pct);
      for (int i = 0; i < N; i++) begin
         if (!(req[i] && !egr[i])) begin
            req[i] = (($urandom % 100) < pct);
            tag[i*TW +: TW] = TW'($urandom);
            val[i*DW +: DW] = DW'($urandom);
         end
      end
   endtask

   task automatic cycle(input int pct);
      @(posedge clk);
      #1 drive_next(pct);
      #4 eval_cycle();
   endtask

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < N; i++) waitc[i] = 0;
      // R8 / R2: reset state with no requests
      repeat (2) @(posedge clk);
      #5;
      chk("R2 idle valid", bv, 1'b0);
      chk("R2 idle tag", bt, '0);
      chk("R2 idle value", bval, '0);
      chk("R1 idle grant", grant, '0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R5: all units busy, grants rotate from unit 0
      for (int k = 0; k < N; k++) begin
         cycle(100);
         chk("R5 rotation", grant, 4'b0001 << k);
      end
      // R6: drain, idle, then burst resumes after last grant (unit 2)
      for (int k = 0; k < 6; k++) cycle(0);
      cycle(100);
      chk("R6 pointer kept over idle", grant, 4'b1000);
      // Random traffic at varied densities
      for (int k = 0; k < 1500; k++) cycle(30);
      for (int k = 0; k < 1500; k++) cycle(85);
      for (int k = 0; k < 500; k++) cycle(($urandom % 2) ? 100 : 10);
      // R8: reset while results are pending
      cycle(100);
      @(posedge clk);
      #1 rst_n = 1'b0;
      ptr_m = 0;
      #4 eval_cycle();
      @(posedge clk);
      #1 rst_n = 1'b1;
      req = '1;
      #4 eval_cycle();
      chk("R8 pointer back to unit 0", grant, 4'b0001);
      for (int k = 0; k < 200; k++) cycle(70);
      finish_run();
   end
endmodule